// File: doc/BRIEF.md
# Peripheral Interrupt Accumulator and Scanner

This block collects interrupt status from a set of peripheral channels, each carrying eight interrupt lines. A line's status bit is set while its input is high at a clock edge and stays set until software clears it. Each channel has an enable bit and a 3-bit owner field. The block folds the enabled channels into 32-bit accumulated words for one owner, picked by the owner-select input, and drives one summary interrupt from those words.

A scanner walks the accumulated words within a channel window. The window's lower and upper bounds widen as software registers channels. For each pending channel it reports the set lines, lowest first, as (channel, line) pairs, one per cycle, with a valid strobe. After the last word in the window it starts again at the first. All configuration and status goes through a single-cycle register port. The address is `{kind[2:0], index[CH_W-1:0]}`, and reads return data in the same cycle.

Top module: `irq_accum_scan`

## Requirements
- R1: Line l of channel n has its status bit at bit l of the word read at kind 2, index n. The bit becomes set at a rising clock edge where `irq_i[n*8+l]` is high. It never becomes set otherwise.
- R2: A write of mask M to kind 3, index n clears the status bits of channel n that are set in M. A one-hot M clears a single line. The other lines of that channel are unchanged.
- R3: A status bit whose input is high in the same cycle as a clear of that bit stays set.
- R4: Bit 0 of the enable register (kind 0, index n) gates the channel. A disabled channel never appears in any accumulated word.
- R5: The owner register (kind 1, index n) holds an owner in bits 2:0. The accumulated word w is read at kind 4, index w. Its bit b is set exactly when channel 32*w+b is enabled, is owned by `ee_sel_i` and has any status bit set.
- R6: `summary_irq_o` is the OR of all accumulated words for the selected owner. It follows status, enable, owner and `ee_sel_i` without added delay.
- R7: The channel bounds read at kind 5, index 0 give the lower bound in bits 7:0 and the upper bound in bits 15:8. They reset to NUM_CH-1 and 0. A write to kind 5, index 1 registers channel `wdata[CH_W-1:0]`, which can only lower the lower bound and raise the upper bound.
- R8: The scanner visits only the accumulated words from lower>>5 to upper>>5. When lower>>5 is greater than upper>>5, it emits nothing.
- R9: Within one pass, words are taken in ascending order and channels lowest bit first. Within each channel, the set lines come out lowest first, one pair per cycle with `scan_valid_o` high.
- R10: After the last word of the window, the scanner restarts at the first word. With stable inputs, the sequence of pairs repeats unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_CH*8 | Line inputs; bit n*8+l is line l of channel n |
| ee_sel_i | input | 3 | Owner whose accumulated words are formed |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | CH_W+3 | Register address {kind, index} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| summary_irq_o | output | 1 | OR of the selected owner's accumulated words |
| scan_valid_o | output | 1 | A pending pair is presented this cycle |
| scan_chan_o | output | CH_W | Channel of the presented pair |
| scan_line_o | output | 3 | Line of the presented pair |

## Verification
The two functions that can fall in the same cycle are a line input setting a status bit and a software clear aimed at that same bit. The bench drives the input high and issues the clear write on the same clock edge. It then reads the status back and expects the bit to remain set. It also clears a neighbouring line while a different line is arriving, to confirm that only the masked bits go.

// File: rtl/intacc_pkg.sv
package intacc_pkg;
    localparam int LINES     = 8;
    localparam int LINE_W    = 3;
    localparam int OWN_W     = 3;
    localparam int WORD_BITS = 32;
    localparam int DATA_W    = 32;

    // register kinds (upper three address bits)
    localparam logic [2:0] K_EN  = 3'd0;
    localparam logic [2:0] K_OWN = 3'd1;
    localparam logic [2:0] K_STS = 3'd2;
    localparam logic [2:0] K_CLR = 3'd3;
    localparam logic [2:0] K_ACC = 3'd4;
    localparam logic [2:0] K_GLB = 3'd5;

    typedef enum logic [1:0] {
        SC_WORD = 2'd0,
        SC_CHAN = 2'd1,
        SC_LINE = 2'd2
    } scan_st_e;

    function automatic logic [4:0] low_bit32(input logic [31:0] v);
        logic [4:0] r;
        r = 5'd0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = 5'(i);
        end
        return r;
    endfunction

    function automatic logic [2:0] low_bit8(input logic [7:0] v);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 7; i >= 0; i--) begin
            if (v[i]) r = 3'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_chan_regs.sv
module irq_chan_regs
    import intacc_pkg::*;
#(
    parameter int NUM_CH = 256,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NUM_CH*LINES-1:0]   irq_i,
    input  logic                      wr_en_i,
    input  logic [2:0]                wr_kind_i,
    input  logic [CH_W-1:0]           wr_idx_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    output logic [NUM_CH*LINES-1:0]   status_o,
    output logic [NUM_CH-1:0]         enable_o,
    output logic [NUM_CH*OWN_W-1:0]   owner_o
);
    localparam int STS_BITS = NUM_CH * LINES;
    localparam int OWN_BITS = NUM_CH * OWN_W;

    typedef struct packed {
        logic [STS_BITS-1:0] sts;
        logic [NUM_CH-1:0]   en;
        logic [OWN_BITS-1:0] own;
    } regs_t;

    regs_t q, d;
    logic [STS_BITS-1:0] clr_mask;

    always_comb begin
        d        = q;
        clr_mask = '0;
        if (wr_en_i && wr_kind_i == K_CLR) begin
            clr_mask[wr_idx_i*LINES +: LINES] = wr_data_i[LINES-1:0];
        end
        // a set arriving with a clear of the same bit wins
        d.sts = (q.sts & ~clr_mask) | irq_i;
        if (wr_en_i && wr_kind_i == K_EN) begin
            d.en[wr_idx_i] = wr_data_i[0];
        end
        if (wr_en_i && wr_kind_i == K_OWN) begin
            d.own[wr_idx_i*OWN_W +: OWN_W] = wr_data_i[OWN_W-1:0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign status_o = q.sts;
    assign enable_o = q.en;
    assign owner_o  = q.own;

    // R1
    sts_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((q.sts & ~$past(q.sts) & ~$past(irq_i)) == '0));

    // R3
    sts_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_i) |=> ((q.sts & $past(irq_i)) == $past(irq_i)));

    // R2
    sts_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_kind_i == K_CLR &&
         ((irq_i[wr_idx_i*LINES +: LINES] & wr_data_i[LINES-1:0]) == '0))
        |=> ((q.sts[$past(wr_idx_i)*LINES +: LINES] & $past(wr_data_i[LINES-1:0])) == '0));
endmodule

// File: rtl/irq_accum_fold.sv
module irq_accum_fold
    import intacc_pkg::*;
#(
    parameter int NUM_CH = 256
) (
    input  logic [NUM_CH*LINES-1:0]  status_i,
    input  logic [NUM_CH-1:0]        enable_i,
    input  logic [NUM_CH*OWN_W-1:0]  owner_i,
    input  logic [OWN_W-1:0]         ee_sel_i,
    output logic [NUM_CH-1:0]        acc_o,
    output logic                     summary_o
);
    // channel n lands in word n>>5 at bit n mod 32, i.e. flat bit n
    for (genvar n = 0; n < NUM_CH; n++) begin : g_fold
        assign acc_o[n] = enable_i[n]
                        & (owner_i[n*OWN_W +: OWN_W] == ee_sel_i)
                        & (|status_i[n*LINES +: LINES]);
    end

    assign summary_o = |acc_o;
endmodule

// File: rtl/irq_scan_bounds.sv
module irq_scan_bounds #(
    parameter int NUM_CH = 256,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            reg_en_i,
    input  logic [CH_W-1:0] reg_ch_i,
    output logic [CH_W-1:0] lo_o,
    output logic [CH_W-1:0] hi_o
);
    typedef struct packed {
        logic [CH_W-1:0] lo;
        logic [CH_W-1:0] hi;
    } bnd_t;

    bnd_t q, d;

    always_comb begin
        d = q;
        if (reg_en_i) begin
            if (reg_ch_i < q.lo) d.lo = reg_ch_i;
            if (reg_ch_i > q.hi) d.hi = reg_ch_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.lo <= CH_W'(NUM_CH - 1);
            q.hi <= '0;
        end else begin
            q <= d;
        end
    end

    assign lo_o = q.lo;
    assign hi_o = q.hi;

    // R7
    lo_widen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (q.lo <= $past(q.lo)));

    // R7
    hi_widen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (q.hi >= $past(q.hi)));
endmodule

// File: rtl/irq_pair_scanner.sv
module irq_pair_scanner
    import intacc_pkg::*;
#(
    parameter int NUM_CH = 256,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_CH-1:0]        acc_i,
    input  logic [NUM_CH*LINES-1:0]  status_i,
    input  logic [CH_W-1:0]          lo_i,
    input  logic [CH_W-1:0]          hi_i,
    output logic                     valid_o,
    output logic [CH_W-1:0]          chan_o,
    output logic [LINE_W-1:0]        line_o
);
    localparam int WIDX_W = CH_W - 5;

    typedef struct packed {
        scan_st_e         st;
        logic [WIDX_W-1:0] wptr;
        logic [31:0]      wsnap;
        logic [CH_W-1:0]  cur;
        logic [LINES-1:0] lsnap;
        logic             vld;
        logic [CH_W-1:0]  och;
        logic [LINE_W-1:0] oline;
    } scan_t;

    scan_t q, d;
    logic [WIDX_W-1:0] first_w, last_w;
    logic [4:0]        bpos;
    logic [LINE_W-1:0] lpos;
    logic [CH_W-1:0]   ch_pick;
    logic              empty_win;

    assign first_w   = lo_i[CH_W-1:5];
    assign last_w    = hi_i[CH_W-1:5];
    assign empty_win = (first_w > last_w);
    assign bpos      = low_bit32(q.wsnap);
    assign lpos      = low_bit8(q.lsnap);
    assign ch_pick   = {q.wptr, bpos};

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (empty_win) begin
            d.st   = SC_WORD;
            d.wptr = first_w;
        end else begin
            case (q.st)
                SC_WORD: begin
                    if (q.wptr < first_w || q.wptr > last_w) begin
                        d.wptr = first_w;
                    end else begin
                        d.wsnap = acc_i[q.wptr*WORD_BITS +: WORD_BITS];
                        d.st    = SC_CHAN;
                    end
                end
                SC_CHAN: begin
                    if (q.wsnap == '0) begin
                        d.wptr = (q.wptr >= last_w) ? first_w : q.wptr + WIDX_W'(1);
                        d.st   = SC_WORD;
                    end else begin
                        d.wsnap[bpos] = 1'b0;
                        d.cur         = ch_pick;
                        d.lsnap       = status_i[ch_pick*LINES +: LINES];
                        d.st          = SC_LINE;
                    end
                end
                SC_LINE: begin
                    if (q.lsnap == '0) begin
                        d.st = SC_CHAN;
                    end else begin
                        d.lsnap[lpos] = 1'b0;
                        d.vld         = 1'b1;
                        d.och         = q.cur;
                        d.oline       = lpos;
                    end
                end
                default: d.st = SC_WORD;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= SC_WORD;
        end else begin
            q <= d;
        end
    end

    assign valid_o = q.vld;
    assign chan_o  = q.och;
    assign line_o  = q.oline;

    // R9
    line_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.vld && $past(q.vld) && q.och == $past(q.och)) |-> (q.oline > $past(q.oline)));

    // R8
    empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        empty_win |=> !q.vld);
endmodule

// File: rtl/irq_accum_scan.sv
module irq_accum_scan
    import intacc_pkg::*;
#(
    parameter int NUM_CH = 256,
    parameter int CH_W   = $clog2(NUM_CH),
    parameter int ADDR_W = CH_W + 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_CH*LINES-1:0]  irq_i,
    input  logic [OWN_W-1:0]         ee_sel_i,
    input  logic                     reg_we_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic [DATA_W-1:0]        reg_wdata_i,
    output logic [DATA_W-1:0]        reg_rdata_o,
    output logic                     summary_irq_o,
    output logic                     scan_valid_o,
    output logic [CH_W-1:0]          scan_chan_o,
    output logic [LINE_W-1:0]        scan_line_o
);
    localparam int WIDX_W = CH_W - 5;

    logic [2:0]               kind;
    logic [CH_W-1:0]          idx;
    logic [NUM_CH*LINES-1:0]  status;
    logic [NUM_CH-1:0]        enable;
    logic [NUM_CH*OWN_W-1:0]  owner;
    logic [NUM_CH-1:0]        acc;
    logic [CH_W-1:0]          lo, hi;
    logic                     bnd_reg;
    logic [7:0]               lo8, hi8;

    assign kind    = reg_addr_i[ADDR_W-1 -: 3];
    assign idx     = reg_addr_i[CH_W-1:0];
    assign bnd_reg = reg_we_i && kind == K_GLB && idx == CH_W'(1);
    assign lo8     = 8'(lo);
    assign hi8     = 8'(hi);

    irq_chan_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .irq_i     (irq_i),
        .wr_en_i   (reg_we_i),
        .wr_kind_i (kind),
        .wr_idx_i  (idx),
        .wr_data_i (reg_wdata_i),
        .status_o  (status),
        .enable_o  (enable),
        .owner_o   (owner)
    );

    irq_accum_fold #(.NUM_CH(NUM_CH)) u_fold (
        .status_i  (status),
        .enable_i  (enable),
        .owner_i   (owner),
        .ee_sel_i  (ee_sel_i),
        .acc_o     (acc),
        .summary_o (summary_irq_o)
    );

    irq_scan_bounds #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bounds (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .reg_en_i (bnd_reg),
        .reg_ch_i (reg_wdata_i[CH_W-1:0]),
        .lo_o     (lo),
        .hi_o     (hi)
    );

    irq_pair_scanner #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_scan (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .acc_i    (acc),
        .status_i (status),
        .lo_i     (lo),
        .hi_i     (hi),
        .valid_o  (scan_valid_o),
        .chan_o   (scan_chan_o),
        .line_o   (scan_line_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (kind)
            K_EN:  reg_rdata_o[0] = enable[idx];
            K_OWN: reg_rdata_o[OWN_W-1:0] = owner[idx*OWN_W +: OWN_W];
            K_STS: reg_rdata_o[LINES-1:0] = status[idx*LINES +: LINES];
            K_ACC: begin
                if (idx[CH_W-1:WIDX_W] == '0) begin
                    reg_rdata_o = acc[idx[WIDX_W-1:0]*WORD_BITS +: WORD_BITS];
                end
            end
            K_GLB: begin
                if (idx == '0) reg_rdata_o[15:0] = {hi8, lo8};
            end
            default: reg_rdata_o = '0;
        endcase
    end

    // R6
    summary_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        summary_irq_o |-> (|status));
endmodule

// File: tb/irq_accum_scan_tb.sv
`timescale 1ns/1ps
module irq_accum_scan_tb;
    localparam int NCH = 64;
    localparam int CW  = 6;
    localparam int AW  = CW + 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH*8-1:0] irq = '0;
    logic [2:0]      ee = '0;
    logic            we = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            summary;
    logic            sv;
    logic [CW-1:0]   sch;
    logic [2:0]      sln;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [7:0] sts_m [NCH];
    bit         en_m  [NCH];
    int         own_m [NCH];
    int         min_m = NCH - 1;
    int         max_m = 0;
    int         exp_ch [NCH*8];
    int         exp_ln [NCH*8];
    int         n_exp;

    always #4 clk = ~clk;

    irq_accum_scan #(.NUM_CH(NCH)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .ee_sel_i(ee),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .summary_irq_o(summary), .scan_valid_o(sv), .scan_chan_o(sch), .scan_line_o(sln)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int kind, input int idx, input logic [31:0] data);
        @(negedge clk);
        we = 1'b1; addr = {3'(kind), 6'(idx)}; wdata = data;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int kind, input int idx, output logic [31:0] data);
        addr = {3'(kind), 6'(idx)};
        #1;
        data = rdata;
    endtask

    task automatic pulse(input logic [NCH*8-1:0] m);
        @(negedge clk);
        irq = m;
        @(negedge clk);
        irq = '0;
        for (int c = 0; c < NCH; c++) sts_m[c] = sts_m[c] | m[c*8 +: 8];
    endtask

    task automatic build_exp(input int owner);
        int first, last;
        n_exp = 0;
        first = min_m >> 5;
        last  = max_m >> 5;
        if (first <= last) begin
            for (int c = first*32; c <= last*32 + 31; c++) begin
                for (int l = 0; l < 8; l++) begin
                    if (en_m[c] && own_m[c] == owner && sts_m[c][l]) begin
                        exp_ch[n_exp] = c;
                        exp_ln[n_exp] = l;
                        n_exp++;
                    end
                end
            end
        end
    endtask

    task automatic scan_check(input string tag);
        int cnt, cyc, i0, seen, k;
        build_exp(int'(ee));
        repeat (300) @(negedge clk);
        if (n_exp == 0) begin
            seen = 0;
            repeat (300) begin
                @(negedge clk);
                if (sv) seen++;
            end
            chk({tag, " R8 empty window emits nothing"}, seen, 0);
        end else begin
            cnt = 0; cyc = 0; i0 = 0;
            while (cnt < 2*n_exp + 3 && cyc < 20000) begin
                @(negedge clk);
                cyc++;
                if (sv) begin
                    if (cnt == 0) begin
                        i0 = -1;
                        for (int j = 0; j < n_exp; j++)
                            if (i0 < 0 && exp_ch[j] == int'(sch) && exp_ln[j] == int'(sln)) i0 = j;
                        if (i0 < 0) i0 = 0;
                    end
                    k = (i0 + cnt) % n_exp;
                    chk({tag, " R9 pair order"}, {16'(sch), 16'(sln)},
                        {16'(exp_ch[k]), 16'(exp_ln[k])});
                    cnt++;
                end
            end
            chk({tag, " R10 repeating passes"}, cnt, 2*n_exp + 3);
        end
    endtask

    task automatic reg_ch(input int c);
        wr(5, 1, 32'(c));
        if (c < min_m) min_m = c;
        if (c > max_m) max_m = c;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [NCH*8-1:0] m;
        logic [31:0] expw;
        for (int c = 0; c < NCH; c++) begin sts_m[c] = '0; en_m[c] = 0; own_m[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R6 summary at reset", summary, 0);
        chk("R9 no valid at reset", sv, 0);
        rd(5, 0, r); chk("R7 reset bounds", r, 32'h0000_003F);
        rd(2, 5, r); chk("R1 status at reset", r, 0);

        // R1/R2 sweep over every channel
        for (int c = 0; c < NCH; c++) begin
            m = '0; m[c*8 + (c % 8)] = 1'b1;
            pulse(m);
            rd(2, c, r); chk("R1 status set", r, 32'(1 << (c % 8)));
            wr(3, c, 32'(1 << (c % 8)));
            sts_m[c] = '0;
            rd(2, c, r); chk("R2 one-hot clear", r, 0);
        end
        for (int l = 0; l < 8; l++) begin
            m = '0; m[l] = 1'b1;
            pulse(m);
            rd(2, 0, r); chk("R1 line sweep", r, 32'(1 << l));
            wr(3, 0, 32'(1 << l)); sts_m[0] = '0;
        end
        m = '0; m[9*8 + 2] = 1'b1; m[9*8 + 5] = 1'b1;
        pulse(m);
        wr(3, 9, 32'h04); sts_m[9] = 8'h20;
        rd(2, 9, r); chk("R2 other lines kept", r, 32'h20);
        wr(3, 9, 32'h20); sts_m[9] = '0;
        rd(2, 9, r); chk("R2 second clear", r, 0);

        // R3: set and clear of the same bit at one edge
        @(negedge clk);
        irq[12*8 + 4] = 1'b1; we = 1'b1; addr = {3'd3, 6'd12}; wdata = 32'h10;
        @(negedge clk);
        irq = '0; we = 1'b0;
        rd(2, 12, r); chk("R3 set wins over clear", r, 32'h10);
        // clear one line while another arrives
        @(negedge clk);
        irq[12*8 + 1] = 1'b1; we = 1'b1; addr = {3'd3, 6'd12}; wdata = 32'h10;
        @(negedge clk);
        irq = '0; we = 1'b0;
        rd(2, 12, r); chk("R3 neighbour clear", r, 32'h02);
        wr(3, 12, 32'h02);

        // R4/R5/R6: enable and owner pattern, fold sweep over owners
        for (int c = 0; c < NCH; c++) begin
            en_m[c] = (c % 3) != 0;
            own_m[c] = c % 4;
            wr(0, c, 32'(en_m[c]));
            wr(1, c, 32'(own_m[c]));
        end
        rd(0, 3, r); chk("R4 enable readback", r, 0);
        rd(1, 7, r); chk("R5 owner readback", r, 3);
        m = '0;
        for (int c = 0; c < NCH; c++) m[c*8 + (c % 8)] = 1'b1;
        m[1*8 + 0] = 1'b1; m[5*8 + 7] = 1'b1; m[13*8 + 3] = 1'b1;
        m[37*8 + 0] = 1'b1; m[41*8 + 7] = 1'b1; m[45*8 + 3] = 1'b1;
        pulse(m);
        for (int e = 0; e < 8; e++) begin
            logic any;
            ee = 3'(e);
            any = 1'b0;
            for (int w = 0; w < 2; w++) begin
                expw = '0;
                for (int b = 0; b < 32; b++)
                    expw[b] = en_m[w*32+b] && own_m[w*32+b] == e && sts_m[w*32+b] != 0;
                any = any | (|expw);
                rd(4, w, r); chk("R4 R5 accumulated word", r, expw);
            end
            chk("R6 summary", summary, any);
        end
        // R4: disabling a pending channel drops it
        ee = 3'd1;
        wr(0, 1, 0); en_m[1] = 0;
        rd(4, 0, r); chk("R4 disabled channel gone", r[1], 0);

        // scanner: empty window at reset bounds
        scan_check("reset bounds");
        reg_ch(40);
        rd(5, 0, r); chk("R7 first registration", r, 32'h0000_2828);
        scan_check("window word1");
        reg_ch(50);
        reg_ch(3);
        reg_ch(10);
        rd(5, 0, r); chk("R7 widened bounds", r, 32'h0000_3203);
        scan_check("window both words");
        ee = 3'd2;
        scan_check("owner 2");
        ee = 3'd1;
        wr(0, 1, 1); en_m[1] = 1;
        scan_check("owner 1 re-enabled");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule